// File: doc/BRIEF.md
# Exception Arbiter and Vector Address Generator

This unit sits next to a small processor core. Every clock it looks at the status reported by instruction decode, the execute stage and the memory port. From that status it picks the single exception the core must take and reports it as a one-cycle strobe. The strobe comes with an 8-bit vector number and the address of the longword table entry holding the handler pointer. The table may sit anywhere in memory, because the fetch address is formed as a relocatable base plus four times the vector number.

The unit also qualifies the external reset request, which needs a sustained low level on two pins. It remembers when a bus-error exception is still being serviced. A further bus fault in that window is fatal: the unit parks in a halted state, goes silent, and stays there until the next qualified reset. Building stack frames, executing instructions and running the bus handshake are left to the core.

Top module: `exc_vector_unit`

## Requirements
- R1: Reset is accepted only after `hw_rst_req_n` and `stop_req_n` have both been sampled low on at least RST_HOLD (default 10) consecutive rising edges. On the first edge after either pin returns high, the unit asserts `exc_take` for one cycle with vector 0 and clears `halted`. A shorter low pulse changes nothing.
- R2: A memory access with `mem_size` equal to 1 (word) or 2 (longword) and `mem_addr0` high raises an address error, vector 3. A byte access (`mem_size` 0) at an odd address and any even access raise nothing.
- R3: `bus_fault_n` low raises a bus error, vector 2, ahead of every condition except reset.
- R4: A bus fault that arrives while an earlier bus error is still being serviced gives no strobe and sets `halted`. While halted no exception is taken, and only R1 clears it.
- R5: With `insn_valid` high, an opcode whose bits 15:12 are 4'hA gives vector 10, and one whose bits 15:12 are 4'hF gives vector 11. Without `insn_valid` these opcodes do nothing.
- R6: With `chk_en` high, vector 6 is raised when `chk_data`, taken as a signed 16-bit value, is below zero or above `chk_bound` taken as signed. Values equal to the bound and zero are in range.
- R7: With `insn_valid` high, opcode 16'h4E40 plus n (n = 0..15) gives vector 32+n. Opcode 16'h4E76 gives vector 7 only when `v_flag` is 1.
- R8: With `insn_valid`, `op_priv` high and `sup_bit` low gives vector 8. `op_priv` with `sup_bit` high gives nothing. `op_illegal` gives vector 4. `div_en` together with `div_by_zero` gives vector 5.
- R9: With `insn_valid` and `trace_bit` high, vector 9 is taken in place of any exception the instruction itself would raise.
- R10: Simultaneous conditions resolve in the order bus error, address error, trace, illegal, line 4'hA, line 4'hF, privilege, TRAP, TRAPV, CHK, divide by zero. Every strobe carries `exc_addr` equal to the `vec_base` of the triggering cycle plus 4 × `exc_vec`, taken modulo 2^ADDR_W. No strobe is given without a condition.
- R11: A `frame_done` pulse ends the bus-error service window, so a later bus fault is again an ordinary bus error.
- R12: Outputs are registered: a condition sampled on one rising edge shows up on `exc_take`, `exc_vec` and `exc_addr` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_req_n | input | 1 | Reset request pin, active low |
| stop_req_n | input | 1 | Stop request pin, active low; must be low with the reset pin |
| bus_fault_n | input | 1 | Bus fault from the memory port, active low |
| insn_valid | input | 1 | An instruction completes this cycle |
| opcode | input | 16 | Opcode of the completing instruction |
| sup_bit | input | 1 | Supervisor state |
| trace_bit | input | 1 | Trace enable |
| v_flag | input | 1 | Overflow flag |
| op_illegal | input | 1 | Decode found an undefined opcode |
| op_priv | input | 1 | Decode found a privileged opcode |
| chk_en | input | 1 | A bounds check executes this cycle |
| chk_data | input | 16 | Operand under test (signed) |
| chk_bound | input | 16 | Upper bound (signed) |
| div_en | input | 1 | A division executes this cycle |
| div_by_zero | input | 1 | The divisor is zero |
| mem_req | input | 1 | A data access is issued |
| mem_size | input | 2 | 0 byte, 1 word, 2 longword |
| mem_addr0 | input | 1 | Bit 0 of the access address |
| vec_base | input | ADDR_W | Relocation base of the vector table |
| frame_done | input | 1 | Core has finished entering the current handler |
| exc_take | output | 1 | One-cycle take-exception strobe |
| exc_vec | output | 8 | Vector number of the taken exception |
| exc_addr | output | ADDR_W | Byte address of the vector table entry |
| halted | output | 1 | Unit stopped after a double bus fault |

## Verification
The hardest state to reach is the halted state and the way out of it. It needs two bus faults with no `frame_done` between them. Then a run of reset-pin cycles must stop exactly one edge short of the qualification count, and another must meet it exactly. The directed part of the bench drives the pins for precise edge counts. It confirms that nine low samples leave `halted` set and a trap ignored, and that ten give the vector-0 strobe. A separate sequence with `frame_done` between two faults shows that the service window closes. The vector table drives each priority pair, both sides of the signed bound, and the byte/word/odd/even access combinations.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int VEC_W = 8;

  // condition sources, index order is the arbitration priority
  localparam int SRC_BERR    = 0;
  localparam int SRC_ADDR    = 1;
  localparam int SRC_TRACE   = 2;
  localparam int SRC_ILLEGAL = 3;
  localparam int SRC_LINE_A  = 4;
  localparam int SRC_LINE_F  = 5;
  localparam int SRC_PRIV    = 6;
  localparam int SRC_TRAP    = 7;
  localparam int SRC_TRAPV   = 8;
  localparam int SRC_CHK     = 9;
  localparam int SRC_DIV0    = 10;
  localparam int NSRC        = 11;

  localparam logic [VEC_W-1:0] VEC_RESET   = 8'd0;
  localparam logic [VEC_W-1:0] VEC_BERR    = 8'd2;
  localparam logic [VEC_W-1:0] VEC_ADDR    = 8'd3;
  localparam logic [VEC_W-1:0] VEC_ILLEGAL = 8'd4;
  localparam logic [VEC_W-1:0] VEC_DIV0    = 8'd5;
  localparam logic [VEC_W-1:0] VEC_CHK     = 8'd6;
  localparam logic [VEC_W-1:0] VEC_TRAPV   = 8'd7;
  localparam logic [VEC_W-1:0] VEC_PRIV    = 8'd8;
  localparam logic [VEC_W-1:0] VEC_TRACE   = 8'd9;
  localparam logic [VEC_W-1:0] VEC_LINE_A  = 8'd10;
  localparam logic [VEC_W-1:0] VEC_LINE_F  = 8'd11;
  localparam logic [VEC_W-1:0] VEC_TRAP0   = 8'd32;

  localparam logic [1:0]  SZ_BYTE     = 2'd0;
  localparam logic [3:0]  NIB_LINE_A  = 4'hA;
  localparam logic [3:0]  NIB_LINE_F  = 4'hF;
  localparam logic [11:0] OP_TRAP_HI  = 12'h4E4;
  localparam logic [15:0] OP_TRAPV    = 16'h4E76;

  // byte offset of a table entry: four bytes per vector
  function automatic logic [VEC_W+1:0] vec_offset(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

  // word and longword accesses must be even
  function automatic logic misaligned(input logic [1:0] size, input logic a0);
    return (size != SZ_BYTE) && a0;
  endfunction

  // signed range test: below zero or above the bound
  function automatic logic chk_out_of_bounds(input logic [15:0] data, input logic [15:0] bound);
    return ($signed(data) < 16'sd0) || ($signed(data) > $signed(bound));
  endfunction

  function automatic logic is_trap(input logic [15:0] op);
    return op[15:4] == OP_TRAP_HI;
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int src, input logic [3:0] trap_num);
    case (src)
      SRC_BERR:    return VEC_BERR;
      SRC_ADDR:    return VEC_ADDR;
      SRC_TRACE:   return VEC_TRACE;
      SRC_ILLEGAL: return VEC_ILLEGAL;
      SRC_LINE_A:  return VEC_LINE_A;
      SRC_LINE_F:  return VEC_LINE_F;
      SRC_PRIV:    return VEC_PRIV;
      SRC_TRAP:    return VEC_TRAP0 | {4'b0000, trap_num};
      SRC_TRAPV:   return VEC_TRAPV;
      SRC_CHK:     return VEC_CHK;
      SRC_DIV0:    return VEC_DIV0;
      default:     return VEC_RESET;
    endcase
  endfunction
endpackage

// File: rtl/exc_rst_qual.sv
`timescale 1ns/1ps
module exc_rst_qual #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic hw_rst_req_n,
  input  logic stop_req_n,
  output logic rst_hold,
  output logic rst_release
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic          both_low;
  logic [CW-1:0] low_cnt;

  assign both_low = !hw_rst_req_n && !stop_req_n;

  // consecutive low samples, saturating at the qualification count
  always_ff @(posedge clk) begin
    if (!both_low)
      low_cnt <= '0;
    else if (low_cnt != LIMIT)
      low_cnt <= low_cnt + 1'b1;
  end

  assign rst_hold    = (low_cnt == LIMIT);
  assign rst_release = rst_hold && !both_low;
endmodule

// File: rtl/exc_detect.sv
`timescale 1ns/1ps
module exc_detect
  import exc_pkg::*;
(
  input  logic            insn_valid,
  input  logic [15:0]     opcode,
  input  logic            sup_bit,
  input  logic            trace_bit,
  input  logic            v_flag,
  input  logic            op_illegal,
  input  logic            op_priv,
  input  logic            chk_en,
  input  logic [15:0]     chk_data,
  input  logic [15:0]     chk_bound,
  input  logic            div_en,
  input  logic            div_by_zero,
  input  logic            mem_req,
  input  logic [1:0]      mem_size,
  input  logic            mem_addr0,
  input  logic            bus_fault_n,
  output logic [NSRC-1:0] req,
  output logic [3:0]      trap_num
);
  always_comb begin
    req               = '0;
    req[SRC_BERR]     = !bus_fault_n;
    req[SRC_ADDR]     = mem_req && misaligned(mem_size, mem_addr0);
    req[SRC_TRACE]    = insn_valid && trace_bit;
    req[SRC_ILLEGAL]  = insn_valid && op_illegal;
    req[SRC_LINE_A]   = insn_valid && (opcode[15:12] == NIB_LINE_A);
    req[SRC_LINE_F]   = insn_valid && (opcode[15:12] == NIB_LINE_F);
    req[SRC_PRIV]     = insn_valid && op_priv && !sup_bit;
    req[SRC_TRAP]     = insn_valid && is_trap(opcode);
    req[SRC_TRAPV]    = insn_valid && (opcode == OP_TRAPV) && v_flag;
    req[SRC_CHK]      = chk_en && chk_out_of_bounds(chk_data, chk_bound);
    req[SRC_DIV0]     = div_en && div_by_zero;
  end

  assign trap_num = opcode[3:0];
endmodule

// File: rtl/exc_prio.sv
`timescale 1ns/1ps
module exc_prio
  import exc_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  input  logic [3:0]       trap_num,
  output logic             any_req,
  output logic [VEC_W-1:0] win_vec
);
  logic [NSRC-1:0] gnt;

  // lowest index wins: mask every request that has a higher-priority one set
  for (genvar i = 0; i < NSRC; i++) begin : g_gnt
    if (i == 0) begin : g_first
      assign gnt[i] = req[i];
    end else begin : g_rest
      assign gnt[i] = req[i] && !(|req[i-1:0]);
    end
  end

  assign any_req = |req;

  always_comb begin
    win_vec = '0;
    for (int k = 0; k < NSRC; k++)
      if (gnt[k]) win_vec = win_vec | src_vector(k, trap_num);
  end
endmodule

// File: rtl/exc_vector_unit.sv
`timescale 1ns/1ps
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int RST_HOLD = 10
) (
  input  logic              clk,
  input  logic              hw_rst_req_n,
  input  logic              stop_req_n,
  input  logic              bus_fault_n,
  input  logic              insn_valid,
  input  logic [15:0]       opcode,
  input  logic              sup_bit,
  input  logic              trace_bit,
  input  logic              v_flag,
  input  logic              op_illegal,
  input  logic              op_priv,
  input  logic              chk_en,
  input  logic [15:0]       chk_data,
  input  logic [15:0]       chk_bound,
  input  logic              div_en,
  input  logic              div_by_zero,
  input  logic              mem_req,
  input  logic [1:0]        mem_size,
  input  logic              mem_addr0,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic              frame_done,
  output logic              exc_take,
  output logic [VEC_W-1:0]  exc_vec,
  output logic [ADDR_W-1:0] exc_addr,
  output logic              halted
);
  // named internal events, also observed by the bound checker
  logic             rst_hold;
  logic             rst_release;
  logic [NSRC-1:0]  req;
  logic [3:0]       trap_num;
  logic             any_req;
  logic [VEC_W-1:0] win_vec;
  logic             berr_busy;
  logic             dbl_fault;
  logic             berr_taken;

  function automatic logic [ADDR_W-1:0] fetch_addr(input logic [VEC_W-1:0] v);
    return vec_base + ADDR_W'(vec_offset(v));
  endfunction

  exc_rst_qual #(.HOLD(RST_HOLD)) u_rst (
    .clk         (clk),
    .hw_rst_req_n(hw_rst_req_n),
    .stop_req_n  (stop_req_n),
    .rst_hold    (rst_hold),
    .rst_release (rst_release)
  );

  exc_detect u_det (
    .insn_valid (insn_valid),
    .opcode     (opcode),
    .sup_bit    (sup_bit),
    .trace_bit  (trace_bit),
    .v_flag     (v_flag),
    .op_illegal (op_illegal),
    .op_priv    (op_priv),
    .chk_en     (chk_en),
    .chk_data   (chk_data),
    .chk_bound  (chk_bound),
    .div_en     (div_en),
    .div_by_zero(div_by_zero),
    .mem_req    (mem_req),
    .mem_size   (mem_size),
    .mem_addr0  (mem_addr0),
    .bus_fault_n(bus_fault_n),
    .req        (req),
    .trap_num   (trap_num)
  );

  exc_prio u_prio (
    .req     (req),
    .trap_num(trap_num),
    .any_req (any_req),
    .win_vec (win_vec)
  );

  assign dbl_fault  = !bus_fault_n && berr_busy;
  assign berr_taken = any_req && (win_vec == VEC_BERR);

  always_ff @(posedge clk) begin
    if (rst_hold) begin
      halted    <= 1'b0;
      berr_busy <= 1'b0;
      exc_take  <= rst_release;
      exc_vec   <= VEC_RESET;
      exc_addr  <= fetch_addr(VEC_RESET);
    end else if (halted) begin
      exc_take  <= 1'b0;
    end else if (dbl_fault) begin
      halted    <= 1'b1;
      exc_take  <= 1'b0;
    end else begin
      exc_take  <= any_req;
      if (any_req) begin
        exc_vec  <= win_vec;
        exc_addr <= fetch_addr(win_vec);
      end
      if (berr_taken)
        berr_busy <= 1'b1;
      else if (frame_done)
        berr_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
`timescale 1ns/1ps
module exc_vector_unit_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              hw_rst_req_n,
  input logic              stop_req_n,
  input logic              bus_fault_n,
  input logic              mem_req,
  input logic [1:0]        mem_size,
  input logic              mem_addr0,
  input logic [ADDR_W-1:0] vec_base,
  input logic              exc_take,
  input logic [7:0]        exc_vec,
  input logic [ADDR_W-1:0] exc_addr,
  input logic              halted,
  input logic              rst_hold,
  input logic              berr_busy
);
  logic live = 1'b0;

  always @(posedge clk)
    if (rst_hold) live <= 1'b1;

  AST_RESET_STROBE: assert property (@(posedge clk) disable iff (!live)
    (rst_hold && (hw_rst_req_n || stop_req_n)) |=> (exc_take && exc_vec == 8'd0 && !halted)); // R1

  AST_ODD_ACCESS: assert property (@(posedge clk) disable iff (!live)
    (!rst_hold && !halted && bus_fault_n && mem_req && mem_addr0 && mem_size != 2'd0)
      |=> (exc_take && exc_vec == 8'd3)); // R2

  AST_BERR_TAKEN: assert property (@(posedge clk) disable iff (!live)
    (!rst_hold && !halted && !bus_fault_n && !berr_busy) |=> (exc_take && exc_vec == 8'd2)); // R3

  AST_DOUBLE_FAULT: assert property (@(posedge clk) disable iff (!live)
    (!rst_hold && !halted && !bus_fault_n && berr_busy) |=> (halted && !exc_take)); // R4

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!live)
    (halted && !rst_hold) |=> halted); // R4

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!live)
    halted |-> !exc_take); // R4

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!live)
    exc_take |-> (exc_addr == ADDR_W'($past(vec_base) + ADDR_W'({exc_vec, 2'b00})))); // R10
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .hw_rst_req_n(hw_rst_req_n),
  .stop_req_n  (stop_req_n),
  .bus_fault_n (bus_fault_n),
  .mem_req     (mem_req),
  .mem_size    (mem_size),
  .mem_addr0   (mem_addr0),
  .vec_base    (vec_base),
  .exc_take    (exc_take),
  .exc_vec     (exc_vec),
  .exc_addr    (exc_addr),
  .halted      (halted),
  .rst_hold    (rst_hold),
  .berr_busy   (berr_busy)
);

// File: tb/test_exc_vector_unit.sv
`timescale 1ns/1ps
module test_exc_vector_unit;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          hw_rst_req_n, stop_req_n, bus_fault_n;
  logic          insn_valid, sup_bit, trace_bit, v_flag, op_illegal, op_priv;
  logic          chk_en, div_en, div_by_zero, mem_req, mem_addr0, frame_done;
  logic [15:0]   opcode, chk_data, chk_bound;
  logic [1:0]    mem_size;
  logic [AW-1:0] vec_base;
  logic          exc_take, halted;
  logic [7:0]    exc_vec;
  logic [AW-1:0] exc_addr;

  int n_checks = 0;
  int n_fail   = 0;

  exc_vector_unit #(.ADDR_W(AW), .RST_HOLD(10)) i_exc_vector_unit (
    .clk(clk), .hw_rst_req_n(hw_rst_req_n), .stop_req_n(stop_req_n), .bus_fault_n(bus_fault_n),
    .insn_valid(insn_valid), .opcode(opcode), .sup_bit(sup_bit), .trace_bit(trace_bit),
    .v_flag(v_flag), .op_illegal(op_illegal), .op_priv(op_priv), .chk_en(chk_en),
    .chk_data(chk_data), .chk_bound(chk_bound), .div_en(div_en), .div_by_zero(div_by_zero),
    .mem_req(mem_req), .mem_size(mem_size), .mem_addr0(mem_addr0), .vec_base(vec_base),
    .frame_done(frame_done), .exc_take(exc_take), .exc_vec(exc_vec), .exc_addr(exc_addr),
    .halted(halted)
  );

  // flags: [9]insn [8]sup [7]trace [6]v [5]illegal [4]priv [3]chk [2]div [1]dz [0]mreq
  typedef struct packed {
    logic [15:0] op;
    logic [9:0]  fl;
    logic [15:0] cd;
    logic [15:0] cb;
    logic [1:0]  msz;
    logic        ma0;
    logic        bn;
    logic        et;
    logic [7:0]  ev;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{16'h4E71, 10'b1100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd10}, // R10 nothing pending
    '{16'hA123, 10'b1100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd10, 8'd5},  // R5
    '{16'hF000, 10'b1100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd11, 8'd5},  // R5
    '{16'hA000, 10'b0100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd5},  // R5 no insn_valid
    '{16'h4E40, 10'b1100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd32, 8'd7},  // R7
    '{16'h4E4F, 10'b1100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd47, 8'd7},  // R7
    '{16'h4E76, 10'b1101000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd7,  8'd7},  // R7 V set
    '{16'h4E76, 10'b1100000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd7},  // R7 V clear
    '{16'h4E71, 10'b0100001000, 16'hFFFF, 16'h0005, 2'd0, 1'b0, 1'b1, 1'b1, 8'd6,  8'd6},  // R6 negative
    '{16'h4E71, 10'b0100001000, 16'h0005, 16'h0005, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd6},  // R6 equal
    '{16'h4E71, 10'b0100001000, 16'h0006, 16'h0005, 2'd0, 1'b0, 1'b1, 1'b1, 8'd6,  8'd6},  // R6 above
    '{16'h4E71, 10'b0100001000, 16'h7FFF, 16'h8000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd6,  8'd6},  // R6 signed bound
    '{16'h4E71, 10'b0100001000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd6},  // R6 zero
    '{16'h4E71, 10'b1000010000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd8,  8'd8},  // R8 user priv
    '{16'h4E71, 10'b1100010000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd8},  // R8 super priv
    '{16'h4E71, 10'b1100100000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd4,  8'd8},  // R8 illegal
    '{16'h4E71, 10'b0100000110, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd5,  8'd8},  // R8 div zero
    '{16'h4E71, 10'b0100000100, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b0, 8'd0,  8'd8},  // R8 div ok
    '{16'h4E71, 10'b0100000001, 16'h0000, 16'h0000, 2'd1, 1'b1, 1'b1, 1'b1, 8'd3,  8'd2},  // R2 odd word
    '{16'h4E71, 10'b0100000001, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 8'd0,  8'd2},  // R2 odd byte
    '{16'h4E71, 10'b0100000001, 16'h0000, 16'h0000, 2'd2, 1'b0, 1'b1, 1'b0, 8'd0,  8'd2},  // R2 even long
    '{16'h4E71, 10'b0100000001, 16'h0000, 16'h0000, 2'd2, 1'b1, 1'b1, 1'b1, 8'd3,  8'd2},  // R2 odd long
    '{16'h4E71, 10'b1110000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd9,  8'd9},  // R9
    '{16'hA123, 10'b1110000000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd9,  8'd9},  // R9 over line A
    '{16'h4E45, 10'b1110000001, 16'h0000, 16'h0000, 2'd1, 1'b1, 1'b1, 1'b1, 8'd3,  8'd10}, // R10 addr over trace
    '{16'h4E71, 10'b0100000001, 16'h0000, 16'h0000, 2'd1, 1'b1, 1'b0, 1'b1, 8'd2,  8'd3},  // R3 over addr
    '{16'h4E71, 10'b1100101110, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd4,  8'd10}, // R10 illegal first
    '{16'h4E42, 10'b1000010000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'd8,  8'd10}  // R10 priv over trap
  };

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_idle();
    insn_valid = 1'b0; opcode = 16'h4E71; sup_bit = 1'b1; trace_bit = 1'b0; v_flag = 1'b0;
    op_illegal = 1'b0; op_priv = 1'b0; chk_en = 1'b0; chk_data = '0; chk_bound = '0;
    div_en = 1'b0; div_by_zero = 1'b0; mem_req = 1'b0; mem_size = 2'd0; mem_addr0 = 1'b0;
    bus_fault_n = 1'b1; frame_done = 1'b0;
  endtask

  task automatic drive_vec(input vec_t v);
    opcode = v.op;
    {insn_valid, sup_bit, trace_bit, v_flag, op_illegal, op_priv, chk_en, div_en, div_by_zero, mem_req} = v.fl;
    chk_data = v.cd; chk_bound = v.cb; mem_size = v.msz; mem_addr0 = v.ma0; bus_fault_n = v.bn;
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [7:0] v);
    return vec_base + AW'(32'(v) * 4);
  endfunction

  // both pins low for n rising edges, then release; returns after the release edge
  task automatic pin_reset(input int n);
    hw_rst_req_n = 1'b0; stop_req_n = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    hw_rst_req_n = 1'b1; stop_req_n = 1'b1;
    step();
  endtask

  task automatic expect_take(input string rq, input logic [7:0] v);
    check(rq, "take", 32'(exc_take), 32'd1);
    check(rq, "vector", 32'(exc_vec), 32'(v));
    check(rq, "fetch address", 32'(exc_addr), 32'(exp_addr(v)));
  endtask

  task automatic idle_done();
    drive_idle();
    frame_done = 1'b1;
    step();
    frame_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    drive_idle();
    vec_base = 24'h001000;
    // R1 power-up reset qualification
    pin_reset(12);
    expect_take("R1", 8'd0);
    check("R1", "halted after reset", 32'(halted), 32'd0);
    step();
    check("R1", "strobe is one cycle", 32'(exc_take), 32'd0);

    // table walk, R12 timing: result sampled right after the driving edge
    for (int i = 0; i < NV; i++) begin
      drive_vec(TBL[i]);
      step();
      check($sformatf("R%0d", TBL[i].rq), $sformatf("take entry %0d", i), 32'(exc_take), 32'(TBL[i].et));
      if (TBL[i].et) begin
        check($sformatf("R%0d", TBL[i].rq), $sformatf("vector entry %0d", i), 32'(exc_vec), 32'(TBL[i].ev));
        check($sformatf("R%0d", TBL[i].rq), $sformatf("address entry %0d", i), 32'(exc_addr), 32'(exp_addr(TBL[i].ev)));
      end
      idle_done();
    end

    // R4 double bus fault
    drive_idle(); bus_fault_n = 1'b0; step();
    expect_take("R3", 8'd2);
    step();
    check("R4", "no strobe on second fault", 32'(exc_take), 32'd0);
    check("R4", "halted set", 32'(halted), 32'd1);
    drive_idle(); insn_valid = 1'b1; opcode = 16'h4E41; step();
    check("R4", "trap ignored while halted", 32'(exc_take), 32'd0);
    drive_idle();

    // R1 nine low samples do not qualify
    pin_reset(9);
    check("R1", "short pulse no strobe", 32'(exc_take), 32'd0);
    check("R1", "short pulse keeps halted", 32'(halted), 32'd1);
    pin_reset(10);
    expect_take("R1", 8'd0);
    check("R1", "reset clears halted", 32'(halted), 32'd0);
    step();

    // R11 frame_done closes the bus error window
    bus_fault_n = 1'b0; step();
    expect_take("R11", 8'd2);
    idle_done();
    bus_fault_n = 1'b0; step();
    expect_take("R11", 8'd2);
    check("R11", "no halt after frame_done", 32'(halted), 32'd0);
    idle_done();

    // R10 relocation with wrap
    vec_base = 24'hFFFFF0;
    insn_valid = 1'b1; opcode = 16'h4E4F; step();
    check("R10", "trap 15 vector", 32'(exc_vec), 32'd47);
    check("R10", "wrapped address", 32'(exc_addr), 32'h0000AC);
    drive_idle(); vec_base = 24'h000000;
    insn_valid = 1'b1; opcode = 16'hF123; step();
    check("R10", "zero base address", 32'(exc_addr), 32'h00002C);
    drive_idle(); step();

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule